// File: doc/BRIEF.md
# Interrupt Enable, Pending and Delegation Register Set

This block holds the machine-level interrupt enable, interrupt pending and interrupt delegation registers of a processor core's control-register file. It also provides the supervisor-level views of the enable and pending registers. These views are not separate storage. They are computed live from the machine registers through the current delegation mask, and a supervisor write lands only on the delegated bits of the machine register behind it.

Each register and each view has its own write strobe and write-data bus. Every register and view also has a read-data output. Three external interrupt sources feed the pending register directly: the machine software interrupt, the machine timer interrupt and the supervisor external interrupt. Software cannot write those three pending bits. A single request output is high whenever any pending bit is set.

Choosing between interrupts and entering a trap are left to the logic that consumes these outputs.

Top module: `irq_csr_top`

## Requirements
- R1: While reset is asserted and right after it, every read output is zero and the request output is low.
- R2: A delegation write stores only bits 1, 5, 9 and 12 of its data. Every other delegation bit stays zero.
- R3: A machine enable write stores only bits 1, 3, 5, 7, 9 and 12 of its data. Every other enable bit stays zero.
- R4: A machine pending write changes only pending bits 1 (supervisor software) and 5 (supervisor timer). Both bits take their values from the write data.
- R5: Pending bits 3, 7 and 9 equal the machine-software, machine-timer and supervisor-external inputs sampled at the previous clock edge. No write changes them.
- R6: The supervisor enable read equals the enable register ANDed with the delegation register. The supervisor pending read equals the pending register ANDed with the delegation register.
- R7: A supervisor enable write replaces exactly those enable bits that are set in the delegation register. All other enable bits are left unchanged.
- R8: A supervisor pending write replaces only those bits that are both delegated and among bits 1 and 5. All other pending bits are left unchanged.
- R9: The request output is high exactly when the pending register is nonzero.
- R10: If a machine write and a supervisor write to the same register fall in the same cycle, the machine write wins on every bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_en_we | input | 1 | Machine enable write strobe |
| m_en_wdata | input | XLEN | Machine enable write data |
| s_en_we | input | 1 | Supervisor enable write strobe |
| s_en_wdata | input | XLEN | Supervisor enable write data |
| m_pend_we | input | 1 | Machine pending write strobe |
| m_pend_wdata | input | XLEN | Machine pending write data |
| s_pend_we | input | 1 | Supervisor pending write strobe |
| s_pend_wdata | input | XLEN | Supervisor pending write data |
| deleg_we | input | 1 | Delegation write strobe |
| deleg_wdata | input | XLEN | Delegation write data |
| src_msw | input | 1 | Machine software interrupt source |
| src_mtimer | input | 1 | Machine timer interrupt source |
| src_sext | input | 1 | Supervisor external interrupt source |
| m_en_rdata | output | XLEN | Machine enable read value |
| s_en_rdata | output | XLEN | Supervisor enable read value |
| m_pend_rdata | output | XLEN | Machine pending read value |
| s_pend_rdata | output | XLEN | Supervisor pending read value |
| deleg_rdata | output | XLEN | Delegation read value |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: a 32-bit register width and the default bit positions (1, 3, 5, 7, 9 and 12). Random write data fills all 32 bits, so the bits above 12 and the non-writable bits below it are exercised on every write, not only the legal ones.

Random delegation values make the supervisor views, and the merge that a supervisor write performs, cover many partial masks. Some cycles carry a machine write and a supervisor write to the same register together, which reaches the same-cycle priority rule.

// File: rtl/irq_csr_pkg.sv
package irq_csr_pkg;
  // default bit positions of the interrupt lines inside each register
  localparam int unsigned DEF_XLEN      = 32;
  localparam int unsigned DEF_POS_SSW   = 1;
  localparam int unsigned DEF_POS_MSW   = 3;
  localparam int unsigned DEF_POS_STMR  = 5;
  localparam int unsigned DEF_POS_MTMR  = 7;
  localparam int unsigned DEF_POS_SEXT  = 9;
  localparam int unsigned DEF_POS_COPR  = 12;
endpackage

// File: rtl/irq_warl_reg.sv
// Masked register with a primary full write port and a secondary write port
// that only reaches bits selected at run time. Non-mask bits are constant 0.
module irq_warl_reg #(
  parameter int unsigned     W    = 32,
  parameter logic [W-1:0]    MASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pri_we,
  input  logic [W-1:0] pri_wdata,
  input  logic         sec_we,
  input  logic [W-1:0] sec_wdata,
  input  logic [W-1:0] sec_sel,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (MASK[i]) begin : g_live
      logic bit_q;
      logic bit_d;
      logic bit_en;
      always_comb begin
        bit_en = pri_we | (sec_we & sec_sel[i]);
        bit_d  = pri_we ? pri_wdata[i] : sec_wdata[i];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bit_q <= 1'b0;
        else if (bit_en) bit_q <= bit_d;
      end
      assign q[i] = bit_q;
    end else begin : g_tied
      assign q[i] = 1'b0;
    end
  end
endmodule

// File: rtl/irq_pend.sv
// Pending register: software-writable bits plus sampled external sources.
module irq_pend #(
  parameter int unsigned  W        = 32,
  parameter logic [W-1:0] SW_MASK  = '0,
  parameter int unsigned  POS_MSW  = 3,
  parameter int unsigned  POS_MTMR = 7,
  parameter int unsigned  POS_SEXT = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         m_we,
  input  logic [W-1:0] m_wdata,
  input  logic         s_we,
  input  logic [W-1:0] s_wdata,
  input  logic [W-1:0] deleg,
  input  logic         src_msw,
  input  logic         src_mtimer,
  input  logic         src_sext,
  output logic [W-1:0] pend,
  output logic         irq
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] sw_q;
  logic [2:0]   ext_q;
  logic [2:0]   ext_d;
  logic [W-1:0] ext_vec;

  irq_warl_reg #(.W(W), .MASK(SW_MASK)) u_sw (
    .clk       (clk),
    .rst_n     (rst_n),
    .pri_we    (m_we),
    .pri_wdata (m_wdata),
    .sec_we    (s_we),
    .sec_wdata (s_wdata),
    .sec_sel   (deleg),
    .q         (sw_q)
  );

  always_comb ext_d = {src_sext, src_mtimer, src_msw};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_q <= 3'b000;
    else        ext_q <= ext_d;
  end

  always_comb begin
    ext_vec = '0;
    if (ext_q[0]) ext_vec = ext_vec | (ONE << POS_MSW);
    if (ext_q[1]) ext_vec = ext_vec | (ONE << POS_MTMR);
    if (ext_q[2]) ext_vec = ext_vec | (ONE << POS_SEXT);
    pend = sw_q | ext_vec;
    irq  = |pend;
  end

  // R5: external bits follow the sources with one cycle of latency
  a_r5_ext_follow: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (pend[POS_MTMR] == $past(src_mtimer)) &&
                     (pend[POS_MSW]  == $past(src_msw)) &&
                     (pend[POS_SEXT] == $past(src_sext)));
endmodule

// File: rtl/irq_csr_top.sv
module irq_csr_top
  import irq_csr_pkg::*;
#(
  parameter int unsigned XLEN     = DEF_XLEN,
  parameter int unsigned POS_SSW  = DEF_POS_SSW,
  parameter int unsigned POS_MSW  = DEF_POS_MSW,
  parameter int unsigned POS_STMR = DEF_POS_STMR,
  parameter int unsigned POS_MTMR = DEF_POS_MTMR,
  parameter int unsigned POS_SEXT = DEF_POS_SEXT,
  parameter int unsigned POS_COPR = DEF_POS_COPR
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            m_en_we,
  input  logic [XLEN-1:0] m_en_wdata,
  input  logic            s_en_we,
  input  logic [XLEN-1:0] s_en_wdata,
  input  logic            m_pend_we,
  input  logic [XLEN-1:0] m_pend_wdata,
  input  logic            s_pend_we,
  input  logic [XLEN-1:0] s_pend_wdata,
  input  logic            deleg_we,
  input  logic [XLEN-1:0] deleg_wdata,
  input  logic            src_msw,
  input  logic            src_mtimer,
  input  logic            src_sext,
  output logic [XLEN-1:0] m_en_rdata,
  output logic [XLEN-1:0] s_en_rdata,
  output logic [XLEN-1:0] m_pend_rdata,
  output logic [XLEN-1:0] s_pend_rdata,
  output logic [XLEN-1:0] deleg_rdata,
  output logic            irq_o
);
  localparam logic [XLEN-1:0] ONE        = {{(XLEN-1){1'b0}}, 1'b1};
  localparam logic [XLEN-1:0] SW_MASK    = (ONE << POS_SSW) | (ONE << POS_STMR);
  localparam logic [XLEN-1:0] DELEG_MASK = SW_MASK | (ONE << POS_SEXT) | (ONE << POS_COPR);
  localparam logic [XLEN-1:0] EN_MASK    = DELEG_MASK | (ONE << POS_MSW) | (ONE << POS_MTMR);
  localparam logic [XLEN-1:0] ZERO       = '0;

  logic [XLEN-1:0] en_q;
  logic [XLEN-1:0] deleg_q;
  logic [XLEN-1:0] pend_q;
  logic            irq_raw;

  irq_warl_reg #(.W(XLEN), .MASK(DELEG_MASK)) u_deleg (
    .clk       (clk),
    .rst_n     (rst_n),
    .pri_we    (deleg_we),
    .pri_wdata (deleg_wdata),
    .sec_we    (1'b0),
    .sec_wdata (ZERO),
    .sec_sel   (ZERO),
    .q         (deleg_q)
  );

  irq_warl_reg #(.W(XLEN), .MASK(EN_MASK)) u_en (
    .clk       (clk),
    .rst_n     (rst_n),
    .pri_we    (m_en_we),
    .pri_wdata (m_en_wdata),
    .sec_we    (s_en_we),
    .sec_wdata (s_en_wdata),
    .sec_sel   (deleg_q),
    .q         (en_q)
  );

  irq_pend #(
    .W(XLEN), .SW_MASK(SW_MASK),
    .POS_MSW(POS_MSW), .POS_MTMR(POS_MTMR), .POS_SEXT(POS_SEXT)
  ) u_pend (
    .clk        (clk),
    .rst_n      (rst_n),
    .m_we       (m_pend_we),
    .m_wdata    (m_pend_wdata),
    .s_we       (s_pend_we),
    .s_wdata    (s_pend_wdata),
    .deleg      (deleg_q),
    .src_msw    (src_msw),
    .src_mtimer (src_mtimer),
    .src_sext   (src_sext),
    .pend       (pend_q),
    .irq        (irq_raw)
  );

  // supervisor views are derived, not stored
  always_comb begin
    m_en_rdata   = en_q;
    deleg_rdata  = deleg_q;
    m_pend_rdata = pend_q;
    s_en_rdata   = en_q & deleg_q;
    s_pend_rdata = pend_q & deleg_q;
    irq_o        = irq_raw;
  end

  // R2: delegation keeps only the delegable bits of a write
  a_r2_deleg_write: assert property (@(posedge clk) disable iff (!rst_n)
    deleg_we |=> deleg_rdata == ($past(deleg_wdata) & DELEG_MASK));

  // R3 and R10: machine enable write stores masked data, beating a supervisor write
  a_r3_en_write: assert property (@(posedge clk) disable iff (!rst_n)
    m_en_we |=> m_en_rdata == ($past(m_en_wdata) & EN_MASK));

  // R4: machine pending write sets exactly the software bits
  a_r4_pend_write: assert property (@(posedge clk) disable iff (!rst_n)
    m_pend_we |=> (m_pend_rdata & SW_MASK) == ($past(m_pend_wdata) & SW_MASK));

  // R7: supervisor enable write leaves undelegated bits alone
  a_r7_s_en_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (s_en_we && !m_en_we) |=>
      ((m_en_rdata ^ $past(m_en_rdata)) & ~$past(deleg_rdata)) == ZERO);

  // R9: any visible supervisor pending bit implies a request
  a_r9_irq_cover: assert property (@(posedge clk) disable iff (!rst_n)
    (s_pend_rdata != ZERO) |-> irq_o);
endmodule

// File: tb/irq_csr_top_tb.sv
module irq_csr_top_tb;
  localparam int XLEN = 32;
  localparam logic [31:0] SWM = 32'h0000_0022;
  localparam logic [31:0] DLM = 32'h0000_1222;
  localparam logic [31:0] ENM = 32'h0000_12AA;

  logic clk = 1'b0;
  logic rst_n;
  logic m_en_we, s_en_we, m_pend_we, s_pend_we, deleg_we;
  logic [31:0] m_en_wdata, s_en_wdata, m_pend_wdata, s_pend_wdata, deleg_wdata;
  logic src_msw, src_mtimer, src_sext;
  logic [31:0] m_en_rdata, s_en_rdata, m_pend_rdata, s_pend_rdata, deleg_rdata;
  logic irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] en_m, dl_m, swp_m;
  logic [2:0]  ext_m;

  always #2.5 clk = ~clk;

  irq_csr_top u_dut (
    .clk(clk), .rst_n(rst_n),
    .m_en_we(m_en_we), .m_en_wdata(m_en_wdata),
    .s_en_we(s_en_we), .s_en_wdata(s_en_wdata),
    .m_pend_we(m_pend_we), .m_pend_wdata(m_pend_wdata),
    .s_pend_we(s_pend_we), .s_pend_wdata(s_pend_wdata),
    .deleg_we(deleg_we), .deleg_wdata(deleg_wdata),
    .src_msw(src_msw), .src_mtimer(src_mtimer), .src_sext(src_sext),
    .m_en_rdata(m_en_rdata), .s_en_rdata(s_en_rdata),
    .m_pend_rdata(m_pend_rdata), .s_pend_rdata(s_pend_rdata),
    .deleg_rdata(deleg_rdata), .irq_o(irq_o)
  );

  function automatic logic [31:0] pend_of(logic [31:0] sw, logic [2:0] ex);
    return sw | (ex[0] ? 32'h8 : 32'h0) | (ex[1] ? 32'h80 : 32'h0) | (ex[2] ? 32'h200 : 32'h0);
  endfunction

  function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] nw, logic [31:0] sel);
    return (old & ~sel) | (nw & sel);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    logic [31:0] p;
    p = pend_of(swp_m, ext_m);
    chk(deleg_rdata == dl_m, "R2", {tag, " deleg"}, deleg_rdata, dl_m);
    chk(m_en_rdata == en_m, "R3", {tag, " enable"}, m_en_rdata, en_m);
    chk(m_pend_rdata == p, "R4", {tag, " pending"}, m_pend_rdata, p);
    chk(s_en_rdata == (en_m & dl_m), "R6", {tag, " s_enable"}, s_en_rdata, en_m & dl_m);
    chk(s_pend_rdata == (p & dl_m), "R6", {tag, " s_pending"}, s_pend_rdata, p & dl_m);
    chk(irq_o == (p != 0), "R9", {tag, " irq"}, {31'b0, irq_o}, {31'b0, p != 0});
  endtask

  task automatic idle_inputs();
    m_en_we = 0; s_en_we = 0; m_pend_we = 0; s_pend_we = 0; deleg_we = 0;
  endtask

  // apply current inputs for one edge, update model, check after the edge
  task automatic cycle(input string tag);
    logic [31:0] en_n, dl_n, sw_n;
    en_n = m_en_we ? (m_en_wdata & ENM)
         : s_en_we ? merge(en_m, s_en_wdata, dl_m & ENM) : en_m;       // R7, R10
    dl_n = deleg_we ? (deleg_wdata & DLM) : dl_m;
    sw_n = m_pend_we ? (m_pend_wdata & SWM)
         : s_pend_we ? merge(swp_m, s_pend_wdata, dl_m & SWM) : swp_m; // R8, R10
    @(posedge clk);
    #1;
    en_m = en_n; dl_m = dl_n; swp_m = sw_n;
    ext_m = {src_sext, src_mtimer, src_msw};                          // R5
    check_all(tag);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'hC5A1));
    rst_n = 0;
    idle_inputs();
    m_en_wdata = '1; s_en_wdata = '1; m_pend_wdata = '1; s_pend_wdata = '1; deleg_wdata = '1;
    src_msw = 1; src_mtimer = 1; src_sext = 1;
    en_m = 0; dl_m = 0; swp_m = 0; ext_m = 0;
    repeat (3) @(negedge clk);
    // R1: reset state with sources active
    check_all("R1 reset");
    src_msw = 0; src_mtimer = 0; src_sext = 0;
    rst_n = 1;
    @(negedge clk);
    check_all("R1 after release");

    // R2: all-ones delegation write keeps only 0x1222
    deleg_we = 1; deleg_wdata = '1; cycle("R2 ones");
    idle_inputs();
    // R3: all-ones enable write keeps only 0x12AA
    m_en_we = 1; m_en_wdata = '1; cycle("R3 ones");
    idle_inputs();
    // R4: all-ones pending write sets only bits 1 and 5; irq rises (R9)
    m_pend_we = 1; m_pend_wdata = '1; cycle("R4 ones");
    idle_inputs();
    m_pend_we = 1; m_pend_wdata = 32'h0; cycle("R9 pending cleared");
    idle_inputs();
    // R5: machine timer source alone, pending write cannot clear it
    src_mtimer = 1; m_pend_we = 1; m_pend_wdata = 32'h0; cycle("R5 timer");
    idle_inputs();
    src_mtimer = 0; cycle("R5 timer drop");
    // R7: delegate only bit 5, supervisor writes zeros to enable
    deleg_we = 1; deleg_wdata = 32'h20; cycle("R7 setup");
    idle_inputs();
    s_en_we = 1; s_en_wdata = 32'h0; cycle("R7 partial");
    idle_inputs();
    // R8: supervisor pending write all ones with only bit 5 delegated
    s_pend_we = 1; s_pend_wdata = '1; cycle("R8 partial");
    idle_inputs();
    // R10: machine and supervisor enable writes together
    m_en_we = 1; m_en_wdata = 32'h0000_0002; s_en_we = 1; s_en_wdata = '1;
    cycle("R10 collide");
    idle_inputs();

    // random phase
    for (int i = 0; i < 3000; i++) begin
      m_en_we     = ($urandom % 4) == 0;
      s_en_we     = ($urandom % 4) == 0;
      m_pend_we   = ($urandom % 5) == 0;
      s_pend_we   = ($urandom % 4) == 0;
      deleg_we    = ($urandom % 6) == 0;
      m_en_wdata  = $urandom;
      s_en_wdata  = $urandom;
      m_pend_wdata = $urandom;
      s_pend_wdata = $urandom;
      deleg_wdata = $urandom;
      src_msw     = ($urandom % 3) == 0;
      src_mtimer  = ($urandom % 3) == 0;
      src_sext    = ($urandom % 3) == 0;
      cycle("random");
    end
    idle_inputs();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule